// File: doc/BRIEF.md
# Processor Status Register with Flag Precedence

This block holds the 8-bit processor status word. It has three kinds of field: the arithmetic flags (zero, half-carry, carry), two cause bits that record power-down and watchdog history, and three bank-select bits that the address path decodes. The register is updated on the clock edge. Three sources can write it: an explicit register write, a per-flag update from the arithmetic unit, and device events (power-up, watchdog clear, sleep and watchdog timeout).

One instruction can name the status word as its destination and also produce new flags. In that case each flag the instruction touches takes the arithmetic result, and the written data for that bit is dropped. Bits the instruction does not touch take the written data. Software cannot write the two cause bits. Only the event strobes change them. The event strobes follow a fixed order of precedence.

The bit layout from bit 7 down to bit 0 is: bank bits (3), timeout cause `to` (bit 4), power-down cause `pd` (bit 3), zero `z` (bit 2), half-carry `dc` (bit 1), carry `c` (bit 0).

Top module: `stat_reg`

## Requirements
- R1: While `rst_n` is low, `status_q` becomes bank bits 0, `to`=1, `pd`=1, and flags equal to parameter `FLAG_RST` (default 0). The default reset value is 8'h18.
- R2: When `wr_en` is high, bits 7:5 and every flag whose `flg_upd` bit is 0 take the value on `wr_data` one clock later.
- R3: `wr_data` bits 4:3 never reach the cause bits. They change only through event strobes.
- R4: A flag whose `flg_upd` bit is 1 takes the matching `flg_val` bit, even when `wr_en` is high in the same cycle. The mask and value bit order is 2=z, 1=dc, 0=c.
- R5: A flag update without a write changes only the masked flags. All other bits hold.
- R6: With no write, no flag update and no event, `status_q` holds its value.
- R7: `ev_sleep` sets `pd` to 0 and `to` to 1.
- R8: `ev_tmo` sets `to` to 0 and leaves `pd` unchanged.
- R9: `ev_wclr` sets both `to` and `pd` to 1.
- R10: `ev_pwr` sets both cause bits to 1 and overrides every other event in the same cycle.
- R11: When events coincide without `ev_pwr`, timeout wins over sleep and clear for `to`, and sleep wins over clear for `pd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Explicit register write strobe |
| wr_data | input | 8 | Write data |
| flg_upd | input | 3 | Per-flag update mask (2=z, 1=dc, 0=c) |
| flg_val | input | 3 | New flag values, same order |
| ev_pwr | input | 1 | Power-up event |
| ev_wclr | input | 1 | Watchdog-clear command |
| ev_sleep | input | 1 | Sleep command |
| ev_tmo | input | 1 | Watchdog timeout |
| status_q | output | 8 | Register value |

## Verification
Several stimulus patterns are applied:
- Plain writes with all bits set tell bank and flag paths apart from the protected cause bits.
- Writes combined with a partial flag mask show that precedence is decided per bit and not for the whole flag field.
- Single event strobes confirm each cause rule.
- Pairs of strobes applied at once expose the precedence order.
- A write that collides with a sleep command shows that the two update paths are independent.
- Idle cycles and a reset in mid-run confirm that the register holds its value and returns to its reset value.

// File: rtl/stat_reg_pkg.sv
package stat_reg_pkg;
   typedef struct packed {
      logic to;
      logic pd;
   } cause_t;

   localparam cause_t CAUSE_POR = '{to: 1'b1, pd: 1'b1};
endpackage

// File: rtl/stat_bank_bits.sv
module stat_bank_bits #(
   parameter int BANK_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BANK_W-1:0] wr_bits,
   output logic [BANK_W-1:0] bank_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)     bank_q <= '0;
      else if (wr_en) bank_q <= wr_bits;
   end
endmodule

// File: rtl/stat_cause_bits.sv
module stat_cause_bits
   import stat_reg_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   ev_pwr,
   input  logic   ev_wclr,
   input  logic   ev_sleep,
   input  logic   ev_tmo,
   output cause_t cause_q
);
   cause_t nxt;

   always_comb begin
      nxt = cause_q;
      if (ev_pwr) begin
         nxt = CAUSE_POR;
      end else begin
         // timeout owns to, sleep owns pd
         if (ev_tmo)                    nxt.to = 1'b0;
         else if (ev_sleep || ev_wclr)  nxt.to = 1'b1;
         if (ev_sleep)                  nxt.pd = 1'b0;
         else if (ev_wclr)              nxt.pd = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cause_q <= CAUSE_POR;
      else        cause_q <= nxt;
   end
endmodule

// File: rtl/stat_flag_bits.sv
module stat_flag_bits #(
   parameter int               FLAG_W   = 3,
   parameter logic [FLAG_W-1:0] FLAG_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [FLAG_W-1:0] wr_bits,
   input  logic [FLAG_W-1:0] upd,
   input  logic [FLAG_W-1:0] val,
   output logic [FLAG_W-1:0] flag_q
);
   for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n)      flag_q[i] <= FLAG_RST[i];
         else if (upd[i]) flag_q[i] <= val[i];
         else if (wr_en)  flag_q[i] <= wr_bits[i];
      end
   end
endmodule

// File: rtl/stat_reg.sv
module stat_reg
   import stat_reg_pkg::*;
#(
   parameter int               BANK_W   = 3,
   parameter int               FLAG_W   = 3,
   parameter logic [FLAG_W-1:0] FLAG_RST = '0,
   localparam int              REG_W    = BANK_W + 2 + FLAG_W,
   localparam int              PD_POS   = FLAG_W,
   localparam int              TO_POS   = FLAG_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wr_data,
   input  logic [FLAG_W-1:0] flg_upd,
   input  logic [FLAG_W-1:0] flg_val,
   input  logic              ev_pwr,
   input  logic              ev_wclr,
   input  logic              ev_sleep,
   input  logic              ev_tmo,
   output logic [REG_W-1:0]  status_q
);
   if (BANK_W < 1 || FLAG_W < 1) begin : g_bad_param
      $error("stat_reg: BANK_W and FLAG_W must be at least 1");
   end

   logic [BANK_W-1:0] bank_q;
   logic [FLAG_W-1:0] flag_q;
   cause_t            cause_q;

   stat_bank_bits #(.BANK_W(BANK_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_bits(wr_data[REG_W-1:TO_POS+1]),
      .bank_q (bank_q)
   );

   stat_cause_bits u_cause (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev_pwr  (ev_pwr),
      .ev_wclr (ev_wclr),
      .ev_sleep(ev_sleep),
      .ev_tmo  (ev_tmo),
      .cause_q (cause_q)
   );

   stat_flag_bits #(.FLAG_W(FLAG_W), .FLAG_RST(FLAG_RST)) u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_bits(wr_data[FLAG_W-1:0]),
      .upd    (flg_upd),
      .val    (flg_val),
      .flag_q (flag_q)
   );

   assign status_q = {bank_q, cause_q.to, cause_q.pd, flag_q};
endmodule

// File: rtl/stat_reg_chk.sv
module stat_reg_chk #(
   parameter int BANK_W = 3,
   parameter int FLAG_W = 3,
   localparam int REG_W  = BANK_W + 2 + FLAG_W,
   localparam int PD_POS = FLAG_W,
   localparam int TO_POS = FLAG_W + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [FLAG_W-1:0] flg_upd,
   input logic [FLAG_W-1:0] flg_val,
   input logic              ev_pwr,
   input logic              ev_wclr,
   input logic              ev_sleep,
   input logic              ev_tmo,
   input logic [REG_W-1:0]  status_q
);
   logic any_ev;
   assign any_ev = ev_pwr | ev_wclr | ev_sleep | ev_tmo;

   a_r3_cause_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      !any_ev |=> $stable(status_q[TO_POS:PD_POS]));

   a_r4_flag_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (flg_upd != '0) |=>
      ((status_q[FLAG_W-1:0] & $past(flg_upd)) == ($past(flg_val) & $past(flg_upd))));

   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_ev && !wr_en && flg_upd == '0) |=> $stable(status_q));

   a_r7_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_sleep && !ev_pwr && !ev_tmo) |=> (status_q[TO_POS] && !status_q[PD_POS]));

   a_r8_timeout: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_tmo && !ev_pwr) |=> !status_q[TO_POS]);

   a_r10_powerup: assert property (@(posedge clk) disable iff (!rst_n)
      ev_pwr |=> (status_q[TO_POS] && status_q[PD_POS]));
endmodule

bind stat_reg stat_reg_chk #(.BANK_W(BANK_W), .FLAG_W(FLAG_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .flg_upd (flg_upd),
   .flg_val (flg_val),
   .ev_pwr  (ev_pwr),
   .ev_wclr (ev_wclr),
   .ev_sleep(ev_sleep),
   .ev_tmo  (ev_tmo),
   .status_q(status_q)
);

// File: tb/stat_reg_tb.sv
`timescale 1ns/1ps
module stat_reg_tb;
   typedef struct packed {
      logic [3:0] req;
      logic       wr;
      logic [7:0] d;
      logic [2:0] u;
      logic [2:0] v;
      logic       p, c, s, t;
      logic [7:0] exp;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VEC [NV] = '{
      '{4'd2,  1'b1, 8'hE7, 3'b000, 3'b000, 1'b0,1'b0,1'b0,1'b0, 8'hFF}, // R2 R3 write all ones
      '{4'd4,  1'b1, 8'h00, 3'b100, 3'b100, 1'b0,1'b0,1'b0,1'b0, 8'h1C}, // R4 clear with z
      '{4'd5,  1'b0, 8'h00, 3'b111, 3'b011, 1'b0,1'b0,1'b0,1'b0, 8'h1B}, // R5 flags only
      '{4'd4,  1'b1, 8'h47, 3'b001, 3'b000, 1'b0,1'b0,1'b0,1'b0, 8'h5E}, // R4 per-bit mask
      '{4'd7,  1'b0, 8'h00, 3'b000, 3'b000, 1'b0,1'b0,1'b1,1'b0, 8'h56}, // R7 sleep
      '{4'd8,  1'b0, 8'h00, 3'b000, 3'b000, 1'b0,1'b0,1'b0,1'b1, 8'h46}, // R8 timeout
      '{4'd9,  1'b0, 8'h00, 3'b000, 3'b000, 1'b0,1'b1,1'b0,1'b0, 8'h5E}, // R9 clear
      '{4'd11, 1'b0, 8'h00, 3'b000, 3'b000, 1'b0,1'b0,1'b1,1'b1, 8'h46}, // R11 tmo+sleep
      '{4'd10, 1'b0, 8'h00, 3'b000, 3'b000, 1'b1,1'b0,1'b0,1'b1, 8'h5E}, // R10 pwr beats tmo
      '{4'd6,  1'b0, 8'hFF, 3'b000, 3'b111, 1'b0,1'b0,1'b0,1'b0, 8'h5E}, // R6 hold
      '{4'd2,  1'b1, 8'h20, 3'b010, 3'b010, 1'b0,1'b0,1'b1,1'b0, 8'h32}, // R2 write with sleep
      '{4'd9,  1'b0, 8'h00, 3'b000, 3'b000, 1'b0,1'b1,1'b0,1'b0, 8'h3A}, // R9 clear
      '{4'd11, 1'b0, 8'h00, 3'b000, 3'b000, 1'b0,1'b1,1'b1,1'b0, 8'h32}, // R11 sleep beats clear
      '{4'd4,  1'b1, 8'hFF, 3'b111, 3'b000, 1'b0,1'b0,1'b0,1'b0, 8'hF0}  // R4 R3 full mask
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [2:0] flg_upd = '0, flg_val = '0;
   logic       ev_pwr = 1'b0, ev_wclr = 1'b0, ev_sleep = 1'b0, ev_tmo = 1'b0;
   logic [7:0] status_q;
   int         n_run = 0, n_fail = 0;

   always #2.5 clk = ~clk;

   stat_reg u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .flg_upd(flg_upd), .flg_val(flg_val), .ev_pwr(ev_pwr),
      .ev_wclr(ev_wclr), .ev_sleep(ev_sleep), .ev_tmo(ev_tmo),
      .status_q(status_q)
   );

   task automatic check(input int req, input logic [7:0] exp);
      n_run++;
      if (status_q !== exp) begin
         n_fail++;
         $display("FAIL R%0d: got %h expected %h", req, status_q, exp);
      end
   endtask

   task automatic idle();
      wr_en = 0; wr_data = '0; flg_upd = '0; flg_val = '0;
      ev_pwr = 0; ev_wclr = 0; ev_sleep = 0; ev_tmo = 0;
   endtask

   initial begin
      #50000;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(1, 8'h18); // R1 reset value
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         wr_en = VEC[i].wr; wr_data = VEC[i].d;
         flg_upd = VEC[i].u; flg_val = VEC[i].v;
         ev_pwr = VEC[i].p; ev_wclr = VEC[i].c;
         ev_sleep = VEC[i].s; ev_tmo = VEC[i].t;
         @(negedge clk);
         check(int'(VEC[i].req), VEC[i].exp);
      end
      // R3: write tries to clear cause bits, both stay 1 after clear event
      idle(); ev_wclr = 1; @(negedge clk);
      wr_en = 1; wr_data = 8'h00; ev_wclr = 0; @(negedge clk);
      check(3, 8'h18);
      // R6: several idle cycles keep value
      idle(); repeat (4) @(negedge clk);
      check(6, 8'h18);
      // R11: timeout beats clear, pd untouched by timeout
      ev_tmo = 1; ev_wclr = 1; @(negedge clk);
      check(11, 8'h08);
      // R1: reset mid-run
      idle(); wr_en = 1; wr_data = 8'hFF; @(negedge clk);
      idle(); rst_n = 0; @(negedge clk);
      check(1, 8'h18);
      rst_n = 1; @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule